// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a circular table of transmit descriptors held in a word-addressed memory and hands each owned buffer to a frame sender. Every descriptor is two consecutive words. The first is an info word carrying an ownership flag, first and last markers, a length and a completion status field. The second is a pointer to the buffer. The engine reads the info word at the current slot. If the engine owns the slot, it reads the pointer and requests a frame send with that address and length. When the sender reports done, the engine writes the info word back with ownership released and the sender's error flags recorded. It then moves to the next slot and checks it at once.

Whenever the current slot is not owned, the engine goes idle and keeps its position. It leaves idle on a host kick or on a tick from an internal poll timer. Dropping the enable stops the engine and returns it to slot zero.

Info word layout: bit 31 is ownership (1 means the engine owns the slot). Bit 29 is FIRST and bit 28 is LAST. Bits 27:24 hold status, with drop at bit 27, deferral at 26, late collision at 25 and underflow at 24. The length sits in the low LEN_W bits. Slot i starts at ring_base + 2*i, with the info word at the even address and the pointer at the next one. The memory returns read data in the cycle after a read request.

Top module: `txring_fetch`

## Requirements
- R1: While ctl_enable is 0, mem_req and frm_req stay 0, tx_done stays 0, and poll_kick is ignored.
- R2: For an owned slot i, the engine reads ring_base+2*i and then ring_base+2*i+1. It then holds frm_req high with frm_addr equal to the pointer word and frm_len equal to info bits [LEN_W-1:0] until frm_done.
- R3: If bit 31 of the info word read is 0, the engine issues no frame request and no write, and it does not advance. A later poll re-reads the same slot.
- R4: After frm_done, the engine writes the info word back to ring_base+2*i. In that word, bit 31 is cleared and bits 27:24 are replaced by frm_err, while all other bits are kept. tx_done is 1 in exactly the cycle of that write.
- R5: After a write-back, the engine reads the next slot without waiting for a poll. The index wraps to 0 after slot ctl_tx_len-1, and a length of 0 or 1 keeps it at slot 0.
- R6: A poll_kick pulse while enabled and idle starts a check of the current slot.
- R7: With poll_div = N > 0, an internal tick starts a check every N cycles while the engine is enabled. With poll_div = 0, no tick occurs.
- R8: Clearing ctl_enable aborts any transfer in progress. After enable is set again, processing resumes from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Engine enable |
| ctl_tx_len | input | 8 | Number of ring slots |
| ring_base | input | AW | Word address of slot 0 |
| poll_div | input | DIV_W | Poll interval in cycles, 0 disables the timer |
| poll_kick | input | 1 | Host request to re-check the current slot |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| frm_req | output | 1 | Frame send request |
| frm_addr | output | 32 | Buffer address of the frame |
| frm_len | output | LEN_W | Frame length |
| frm_done | input | 1 | Frame send finished |
| frm_err | input | 4 | Send error flags: drop, deferral, late collision, underflow |
| tx_done | output | 1 | One-cycle pulse per write-back |

## Verification
The bench targets four behaviours:
- Slot not owned: a design that advanced past such a slot would skip the descriptor the host fills in later, and the following write-back address would not match.
- Wrap: rings of four slots and of one slot are used. A design that wrapped late, or took its length from the wrong field, would read beyond the ring.
- Timer: it is exercised both disabled and at a small divisor, so a stuck or free-running timer shows up as missing or unexpected activity.
- Restart: the enable is dropped while the index is mid-ring. A design that kept its index would look at a released slot and go silent instead of sending slot zero.

// File: rtl/txr_pkg.sv
package txr_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_RD_INFO,
      S_CHK_INFO,
      S_RD_PTR,
      S_CAP_PTR,
      S_SEND,
      S_WB
   } txr_state_e;

   localparam int OWN_BIT   = 31;
   localparam int FIRST_BIT = 29;
   localparam int LAST_BIT  = 28;
   localparam int ERR_LSB   = 24;
   localparam int ERR_W     = 4;
endpackage

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
   parameter int DIV_W     = 16,
   parameter bit HAS_TIMER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   generate
      if (DIV_W < 1) begin : g_bad_w
         $error("txr_poll_timer: DIV_W must be at least 1");
      end
      if (HAS_TIMER) begin : g_timer
         logic [DIV_W-1:0] cnt_q;
         logic             tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               tick_q <= 1'b0;
            end else if (!run || div == '0) begin
               cnt_q  <= '0;
               tick_q <= 1'b0;
            end else if (cnt_q >= div - 1'b1) begin
               cnt_q  <= '0;
               tick_q <= 1'b1;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
               tick_q <= 1'b0;
            end
         end
         assign tick = tick_q;

         // R7: ticks are spaced by the divisor, never back to back for N > 1
         p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_q && div > 1 && $stable(div)) |=> !tick_q);
      end else begin : g_no_timer
         assign tick = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/txr_ring_index.sv
module txr_ring_index #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [IDX_W-1:0] len,
   output logic [IDX_W-1:0] idx
);
   localparam int NW = IDX_W + 1;

   logic [IDX_W-1:0] idx_q;
   logic [NW-1:0]    nxt;

   assign nxt = {1'b0, idx_q} + NW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (clear)
         idx_q <= '0;
      else if (step)
         idx_q <= (nxt >= {1'b0, len}) ? '0 : nxt[IDX_W-1:0];
   end

   assign idx = idx_q;
endmodule

// File: rtl/txr_engine.sv
module txr_engine
   import txr_pkg::*;
#(
   parameter int AW    = 16,
   parameter int IDX_W = 8,
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             poll_req,
   input  logic [IDX_W-1:0] idx,
   input  logic [AW-1:0]    ring_base,
   output logic             step,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   output logic             frm_req,
   output logic [31:0]      frm_addr,
   output logic [LEN_W-1:0] frm_len,
   input  logic             frm_done,
   input  logic [ERR_W-1:0] frm_err,
   output logic             tx_done
);
   localparam int HI_W = OWN_BIT - LAST_BIT;

   txr_state_e       state_q;
   logic             pend_q;
   logic [HI_W-1:0]  info_hi_q;
   logic [ERR_LSB-1:0] info_lo_q;
   logic [31:0]      ptr_q;
   logic [ERR_W-1:0] err_q;
   logic [AW-1:0]    desc_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         pend_q    <= 1'b0;
         info_hi_q <= '0;
         info_lo_q <= '0;
         ptr_q     <= '0;
         err_q     <= '0;
      end else if (!en) begin
         state_q <= S_IDLE;
         pend_q  <= 1'b0;
      end else begin
         pend_q <= pend_q | poll_req;
         case (state_q)
            S_IDLE: begin
               if (pend_q || poll_req) begin
                  state_q <= S_RD_INFO;
                  pend_q  <= 1'b0;
               end
            end
            S_RD_INFO: state_q <= S_CHK_INFO;
            S_CHK_INFO: begin
               info_hi_q <= mem_rdata[OWN_BIT-1:LAST_BIT];
               info_lo_q <= mem_rdata[ERR_LSB-1:0];
               state_q   <= mem_rdata[OWN_BIT] ? S_RD_PTR : S_IDLE;
            end
            S_RD_PTR: state_q <= S_CAP_PTR;
            S_CAP_PTR: begin
               ptr_q   <= mem_rdata;
               state_q <= S_SEND;
            end
            S_SEND: begin
               if (frm_done) begin
                  err_q   <= frm_err;
                  state_q <= S_WB;
               end
            end
            S_WB: state_q <= S_RD_INFO;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign desc_addr = ring_base + AW'({idx, 1'b0});

   always_comb begin
      mem_req  = (state_q == S_RD_INFO) || (state_q == S_RD_PTR) || (state_q == S_WB);
      mem_we   = (state_q == S_WB);
      mem_addr = (state_q == S_RD_PTR) ? desc_addr + AW'(1) : desc_addr;
   end

   assign mem_wdata = {1'b0, info_hi_q, err_q, info_lo_q};
   assign frm_req   = (state_q == S_SEND);
   assign frm_addr  = ptr_q;
   assign frm_len   = info_lo_q[LEN_W-1:0];
   assign tx_done   = (state_q == S_WB);
   assign step      = (state_q == S_WB);

   // R6: a poll seen while idle starts the info read in the next cycle
   p_poll_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && en && poll_req) |=> (state_q == S_RD_INFO));

   // R2: a frame request holds with a stable buffer address until done
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_req && !frm_done && en) |=> (frm_req && $stable(frm_addr)));
endmodule

// File: rtl/txring_fetch.sv
module txring_fetch
   import txr_pkg::*;
#(
   parameter int AW        = 16,
   parameter int IDX_W     = 8,
   parameter int LEN_W     = 11,
   parameter int DIV_W     = 16,
   parameter bit HAS_TIMER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_enable,
   input  logic [7:0]       ctl_tx_len,
   input  logic [AW-1:0]    ring_base,
   input  logic [DIV_W-1:0] poll_div,
   input  logic             poll_kick,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   output logic             frm_req,
   output logic [31:0]      frm_addr,
   output logic [LEN_W-1:0] frm_len,
   input  logic             frm_done,
   input  logic [3:0]       frm_err,
   output logic             tx_done
);
   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("txring_fetch: IDX_W must be 1..8");
      end
      if (AW <= IDX_W + 1) begin : g_bad_aw
         $error("txring_fetch: AW too small for ring");
      end
      if (LEN_W < 1 || LEN_W > ERR_LSB) begin : g_bad_len
         $error("txring_fetch: LEN_W must fit below status field");
      end
   endgenerate

   logic             tick;
   logic             step;
   logic [IDX_W-1:0] idx;

   txr_poll_timer #(.DIV_W(DIV_W), .HAS_TIMER(HAS_TIMER)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ctl_enable),
      .div  (poll_div),
      .tick (tick)
   );

   txr_ring_index #(.IDX_W(IDX_W)) u_index (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(!ctl_enable),
      .step (step),
      .len  (ctl_tx_len[IDX_W-1:0]),
      .idx  (idx)
   );

   txr_engine #(.AW(AW), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctl_enable),
      .poll_req (poll_kick | tick),
      .idx      (idx),
      .ring_base(ring_base),
      .step     (step),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata),
      .frm_req  (frm_req),
      .frm_addr (frm_addr),
      .frm_len  (frm_len),
      .frm_done (frm_done),
      .frm_err  (frm_err),
      .tx_done  (tx_done)
   );

   // R1: once disabled, no memory or frame request follows
   p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_enable |=> (!mem_req && !frm_req));

   // R4: every write-back releases ownership
   p_wb_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);
endmodule

// File: tb/tb_txring_fetch.sv
module tb_txring_fetch;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int LEN_W = 11;
   localparam int DIV_W = 16;
   localparam logic [15:0] BASE = 16'h0040;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ctl_enable = 1'b0;
   logic [7:0]       ctl_tx_len = 8'd4;
   logic [AW-1:0]    ring_base = BASE;
   logic [DIV_W-1:0] poll_div = '0;
   logic             poll_kick = 1'b0;
   logic             mem_req, mem_we, frm_req, tx_done;
   logic [AW-1:0]    mem_addr;
   logic [31:0]      mem_wdata, frm_addr;
   logic [31:0]      mem_rdata = '0;
   logic [LEN_W-1:0] frm_len;
   logic             frm_done = 1'b0;
   logic [3:0]       frm_err = '0;

   int n_cmp = 0, n_bad = 0;
   int wr_cnt = 0, frm_cnt = 0, req_cnt = 0;
   logic [63:0] frm_q[$];
   logic [63:0] wb_q[$];
   logic [3:0]  err_q[$];
   logic [31:0] mem [0:255];
   logic [3:0]  cur_err = '0;
   bit          frm_seen = 1'b0;
   int          wait_c = 0;

   txring_fetch dut (
      .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_tx_len(ctl_tx_len),
      .ring_base(ring_base), .poll_div(poll_div), .poll_kick(poll_kick),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .frm_req(frm_req), .frm_addr(frm_addr), .frm_len(frm_len),
      .frm_done(frm_done), .frm_err(frm_err), .tx_done(tx_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[7:0]];
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares frames and write-backs against the scoreboard queues
   always @(negedge clk) begin
      if (mem_req) req_cnt++;
      if (tx_done != (mem_req && mem_we))
         check(1'b0, "R4 tx_done with write", {63'd0, tx_done}, {63'd0, mem_req && mem_we});
      if (mem_req && mem_we) begin
         wr_cnt++;
         if (wb_q.size() == 0) check(1'b0, "R3 unexpected write", {16'd0, mem_addr, mem_wdata}, 64'd0);
         else begin
            logic [63:0] e;
            e = wb_q.pop_front();
            check(mem_addr == e[47:32] && mem_wdata == e[31:0], "R4 write-back",
                  {16'd0, mem_addr, mem_wdata}, e);
         end
      end
      if (frm_done) frm_done = 1'b0;
      else if (frm_req) begin
         if (!frm_seen) begin
            frm_seen = 1'b1;
            wait_c = 0;
            frm_cnt++;
            if (frm_q.size() == 0) check(1'b0, "R3 unexpected frame", {frm_addr, 21'd0, frm_len}, 64'd0);
            else begin
               logic [63:0] e;
               e = frm_q.pop_front();
               check(frm_addr == e[63:32] && 32'(frm_len) == e[31:0], "R2 frame request",
                     {frm_addr, 21'd0, frm_len}, e);
            end
            cur_err = (err_q.size() != 0) ? err_q.pop_front() : 4'd0;
         end else begin
            wait_c++;
            if (wait_c == 2) begin
               frm_done = 1'b1;
               frm_err  = cur_err;
               frm_seen = 1'b0;
            end
         end
      end
   end

   task automatic put_desc(input int i, input logic [31:0] ptr, input int len,
                           input bit own, input logic [3:0] err, input logic [3:0] stale);
      logic [15:0] a;
      logic [31:0] info;
      a = BASE + 16'(2 * i);
      info = 32'h3010_0000 | (32'(stale) << 24) | 32'(len);
      if (own) info = info | 32'h8000_0000;
      mem[a[7:0]] <= info;
      mem[a[7:0] + 8'd1] <= ptr;
      if (own) begin
         frm_q.push_back({ptr, 32'(len)});
         err_q.push_back(err);
         wb_q.push_back({16'd0, a, (info & ~32'h8F00_0000) | (32'(err) << 24)});
      end
   endtask

   task automatic kick();
      @(negedge clk) poll_kick = 1'b1;
      @(negedge clk) poll_kick = 1'b0;
   endtask

   task automatic drain(input string tag, input int lim);
      for (int k = 0; k < lim; k++) begin
         if (frm_q.size() == 0 && wb_q.size() == 0) break;
         @(negedge clk);
      end
      check(frm_q.size() == 0 && wb_q.size() == 0, tag,
            64'(frm_q.size() + wb_q.size()), 64'd0);
      repeat (8) @(negedge clk);
   endtask

   task automatic quiet(input string tag, input int n);
      int w0, f0;
      w0 = wr_cnt; f0 = frm_cnt;
      repeat (n) @(negedge clk);
      check(wr_cnt == w0 && frm_cnt == f0, tag, 64'(wr_cnt + frm_cnt), 64'(w0 + f0));
   endtask

   initial begin
      repeat (CLK_PERIOD * 150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < 256; k++) mem[k] <= '0;
      repeat (3) @(negedge clk);
      check(!mem_req && !frm_req && !tx_done, "R1 reset outputs",
            {61'd0, mem_req, frm_req, tx_done}, 64'd0);
      rst_n = 1'b1;
      // R1: disabled engine ignores kicks even with an owned slot
      put_desc(0, 32'h0000_1000, 60, 1'b1, 4'h0, 4'h0);
      kick(); kick();
      repeat (10) @(negedge clk);
      check(req_cnt == 0 && !frm_req, "R1 disabled ignores kick", 64'(req_cnt), 64'd0);
      frm_q.delete(); wb_q.delete(); err_q.delete();

      // R3: slot not owned, stays idle
      ctl_tx_len = 8'd4;
      ctl_enable = 1'b1;
      put_desc(0, 32'h0000_1000, 60, 1'b0, 4'h0, 4'h0);
      kick();
      quiet("R3 not owned stays idle", 20);

      // R2/R4/R6: two frames after a kick, second reports errors over stale status
      put_desc(0, 32'h0000_1000, 60, 1'b1, 4'h0, 4'h0);
      put_desc(1, 32'h0000_2000, 1514, 1'b1, 4'hA, 4'h3);
      kick();
      drain("R6 kick processes owned slots", 200);
      check(frm_cnt == 2, "R5 consecutive slots without poll", 64'(frm_cnt), 64'd2);

      // R3: index held at slot 2 while it was not owned
      put_desc(2, 32'h0000_2400, 100, 1'b1, 4'h1, 4'h0);
      kick();
      drain("R3 same slot re-read", 200);

      // R5: wrap from slot 3 to slot 0
      put_desc(3, 32'h0000_2800, 64, 1'b1, 4'h0, 4'h0);
      put_desc(0, 32'h0000_3000, 128, 1'b1, 4'h4, 4'h0);
      kick();
      drain("R5 wrap to slot 0", 200);

      // R7: timer off, then on
      put_desc(1, 32'h0000_3400, 200, 1'b1, 4'h0, 4'h0);
      quiet("R7 no tick when divisor zero", 100);
      poll_div = 16'd25;
      drain("R7 timer tick starts check", 80);
      poll_div = 16'd0;
      repeat (5) @(negedge clk);

      // R8: restart from slot 0 after enable toggles mid-ring
      ctl_enable = 1'b0;
      repeat (5) @(negedge clk);
      check(!mem_req && !frm_req, "R1 disabled outputs", {62'd0, mem_req, frm_req}, 64'd0);
      ctl_enable = 1'b1;
      put_desc(0, 32'h0000_3800, 300, 1'b1, 4'h2, 4'h0);
      kick();
      drain("R8 restart at slot 0", 200);

      // R8: abort mid-send, then resume from slot 0
      put_desc(1, 32'h0000_3C00, 90, 1'b1, 4'h0, 4'h0);
      kick();
      for (int k = 0; k < 50 && !frm_req; k++) @(negedge clk);
      ctl_enable = 1'b0;
      @(negedge clk);
      check(!frm_req, "R8 abort drops request", {63'd0, frm_req}, 64'd0);
      frm_q.delete(); wb_q.delete(); err_q.delete();
      frm_seen = 1'b0;
      repeat (4) @(negedge clk);

      // R5: one-slot ring always wraps to slot 0
      ctl_tx_len = 8'd1;
      ctl_enable = 1'b1;
      put_desc(0, 32'h0000_4000, 77, 1'b1, 4'h8, 4'h0);
      kick();
      drain("R5 single slot ring first", 200);
      put_desc(0, 32'h0000_4400, 78, 1'b1, 4'h0, 4'h0);
      kick();
      drain("R5 single slot ring wrap", 200);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule